// File: doc/BRIEF.md
# Counting Semaphore Cell

A single synchronisation cell that keeps a 16-bit counting semaphore for up to `NREQ` requesters sharing one access port. A read through one of the two semaphore views takes the semaphore, and a write through either of them gives it back. The blocking view differs from the try view only on a read of a zero count. A blocking take of an empty semaphore is refused on the `acc_ready` handshake, and the requester's ID is noted in a blocked mask. A try take of an empty semaphore completes and returns 0.

Any give releases every noted requester at once. The cell pulses `wake` with the old mask for one cycle and clears the mask. A released requester is expected to retry its take. If others have drained the count by then, it stalls again and its bit is set once more. A raw view returns the count without touching it.

Top module: `sem_cell`

## Requirements
- R1: After reset the count is 0, `blocked` and `wake` are 0, `rsp_valid` is 0 and `acc_ready` is 1.
- R2: An accepted read drives `rsp_valid` high in the next cycle, with `rsp_data` equal to the count as it was before the access. View codes: 0 raw, 1 blocking, 2 try, 3 inert.
- R3: An accepted read in view 1 or 2 on a nonzero count decrements the count by one.
- R4: A read in view 1 on a zero count drops `acc_ready` in the same cycle and produces no response. It leaves the count unchanged and sets bit `acc_id` of `blocked` from the next cycle on.
- R5: A read in view 2 on a zero count is accepted, returns 0 and leaves the count at 0.
- R6: A write in view 1 or 2 increments the count, which saturates at 0xFFFF. The cell has no write data.
- R7: A write in view 1 or 2 clears `blocked` and, in the next cycle, pulses `wake` for one cycle with the mask held before the write.
- R8: Writes in view 1 and view 2 behave identically.
- R9: A raw-view read returns the count without changing it, and a raw-view write has no effect on the count or on `blocked`.
- R10: A view 3 read returns 0, and a view 3 write has no effect.
- R11: When `acc_rd` and `acc_wr` are both high in the same cycle, the read is performed and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_rd | input | 1 | Read strobe (take in views 1 and 2) |
| acc_wr | input | 1 | Write strobe (give in views 1 and 2) |
| acc_view | input | 2 | View code: 0 raw, 1 blocking, 2 try, 3 inert |
| acc_id | input | IDW | Requester ID |
| acc_ready | output | 1 | Access accepted this cycle; low on a stalled take |
| rsp_data | output | 16 | Read data |
| rsp_valid | output | 1 | Read data valid |
| blocked | output | NREQ | One bit per stalled requester |
| wake | output | NREQ | One-cycle release pulse per requester |

## Verification
The bench drives the count to exactly 0xFFFF and gives twice more. A cell that wrapped would then report 0 or 1 where 0xFFFF is expected. Blocking and try takes are applied to an empty semaphore. A design that decremented through zero would return 0xFFFF on a later raw read, and one that stalled the try view would drop `acc_ready` where it must stay high. A released requester retries after another requester has taken the only unit, and it must appear in `blocked` again. A design that granted on release instead of re-stalling would answer that retry. A give issued together with a read must be dropped, or the count observed afterwards is one too high.

// File: rtl/sem_cell.sv
module sem_cell #(
  parameter int NREQ = 8,
  parameter int CW   = 16,
  parameter int IDW  = (NREQ > 1) ? $clog2(NREQ) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc_rd,
  input  logic            acc_wr,
  input  logic [1:0]      acc_view,
  input  logic [IDW-1:0]  acc_id,
  output logic            acc_ready,
  output logic [CW-1:0]   rsp_data,
  output logic            rsp_valid,
  output logic [NREQ-1:0] blocked,
  output logic [NREQ-1:0] wake
);
  localparam logic [1:0]    V_RAW   = 2'd0;
  localparam logic [1:0]    V_BLOCK = 2'd1;
  localparam logic [1:0]    V_TRY   = 2'd2;
  localparam logic [CW-1:0] MAXV    = '1;

  logic [CW-1:0] count;

  wire is_sem = (acc_view == V_BLOCK) || (acc_view == V_TRY);
  wire empty  = (count == '0);
  wire stall  = acc_rd && (acc_view == V_BLOCK) && empty;
  wire take   = acc_rd && is_sem && !stall;
  wire give   = acc_wr && !acc_rd && is_sem;

  assign acc_ready = !stall;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count     <= '0;
      blocked   <= '0;
      wake      <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= acc_rd && !stall;
      if (acc_rd)
        rsp_data <= (is_sem || acc_view == V_RAW) ? count : '0;
      if (take && !empty)
        count <= count - 1'b1;
      else if (give && count != MAXV)
        count <= count + 1'b1;
      wake <= give ? blocked : '0;
      if (stall)
        blocked <= blocked | (NREQ'(1) << acc_id);
      else if (give)
        blocked <= '0;
    end
  end

  assert_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && !stall) |=> rsp_valid);

  assert_dec_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !empty) |=> count == $past(count) - 1'b1);

  assert_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (blocked[$past(acc_id)] && $stable(count) && !rsp_valid));

  assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (give && count == MAXV) |=> count == MAXV);

  assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    give |=> (blocked == '0 && wake == $past(blocked)));

  assert_wake_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !give |=> wake == '0);
endmodule

// File: tb/sem_cell_test.sv
`timescale 1ns/1ps
module sem_cell_test;
  localparam int NREQ = 8;
  localparam int IDW  = 3;
  localparam time TCK = 20ns;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            acc_rd = 1'b0, acc_wr = 1'b0;
  logic [1:0]      acc_view = 2'd0;
  logic [IDW-1:0]  acc_id = '0;
  logic            acc_ready, rsp_valid;
  logic [15:0]     rsp_data;
  logic [NREQ-1:0] blocked, wake;

  int nchk = 0, nfail = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #(TCK/2) clk = ~clk;

  sem_cell #(.NREQ(NREQ), .CW(16)) uut (
    .clk(clk), .rst_n(rst_n), .acc_rd(acc_rd), .acc_wr(acc_wr),
    .acc_view(acc_view), .acc_id(acc_id), .acc_ready(acc_ready),
    .rsp_data(rsp_data), .rsp_valid(rsp_valid), .blocked(blocked), .wake(wake));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: pops one expected item per response
  always @(negedge clk) if (rst_n && rsp_valid) begin
    if (exp_q.size() == 0) check("R4 unexpected response", 32'(rsp_data), 32'hDEAD);
    else check(tag_q.pop_front(), 32'(rsp_data), 32'(exp_q.pop_front()));
  end

  task automatic rd(input logic [1:0] v, input int id, input logic [15:0] e, input string req);
    @(negedge clk);
    acc_rd = 1'b1; acc_view = v; acc_id = IDW'(id);
    exp_q.push_back(e); tag_q.push_back(req);
    #2 check({req, " ready"}, 32'(acc_ready), 1);
    @(negedge clk);
    acc_rd = 1'b0;
  endtask

  task automatic stall(input int id, input logic [NREQ-1:0] emask, input string req);
    @(negedge clk);
    acc_rd = 1'b1; acc_view = 2'd1; acc_id = IDW'(id);
    #2 check({req, " ready low"}, 32'(acc_ready), 0);
    @(negedge clk);
    acc_rd = 1'b0;
    #1 check({req, " blocked"}, 32'(blocked), 32'(emask));
  endtask

  task automatic wr(input logic [1:0] v, input int id, input logic [NREQ-1:0] ewake,
                    input logic [NREQ-1:0] eblk, input string req);
    @(negedge clk);
    acc_wr = 1'b1; acc_view = v; acc_id = IDW'(id);
    @(negedge clk);
    acc_wr = 1'b0;
    #1 check({req, " wake"}, 32'(wake), 32'(ewake));
    check({req, " blocked"}, 32'(blocked), 32'(eblk));
  endtask

  initial begin
    #(TCK * 200000);
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 ready", 32'(acc_ready), 1);
    check("R1 rsp_valid", 32'(rsp_valid), 0);
    check("R1 blocked", 32'(blocked), 0);
    check("R1 wake", 32'(wake), 0);
    rd(2'd0, 0, 16'd0, "R1 count");

    rd(2'd2, 1, 16'd0, "R5 try on zero");
    rd(2'd0, 1, 16'd0, "R5 count kept");

    stall(3, 8'h08, "R4 id3");
    stall(5, 8'h28, "R4 id5");
    rd(2'd0, 0, 16'd0, "R4 count kept");

    wr(2'd0, 0, 8'h00, 8'h28, "R9 raw write");
    wr(2'd3, 0, 8'h00, 8'h28, "R10 inert write");
    rd(2'd3, 0, 16'd0, "R10 inert read");
    rd(2'd0, 0, 16'd0, "R9 count after ignored writes");

    wr(2'd1, 0, 8'h28, 8'h00, "R7 release all");
    wr(2'd2, 0, 8'h00, 8'h00, "R8 try give");
    rd(2'd0, 0, 16'd2, "R8 count two");
    rd(2'd0, 0, 16'd2, "R9 raw read no change");

    rd(2'd1, 3, 16'd2, "R2 blocking take");
    rd(2'd2, 5, 16'd1, "R3 try take");
    rd(2'd0, 0, 16'd0, "R3 drained");

    stall(2, 8'h04, "R4 id2");
    wr(2'd2, 6, 8'h04, 8'h00, "R7 release id2");
    rd(2'd1, 4, 16'd1, "R3 other takes unit");
    stall(2, 8'h04, "R4 retry stalls again");

    // both strobes: read wins, give dropped
    @(negedge clk);
    acc_rd = 1'b1; acc_wr = 1'b1; acc_view = 2'd2; acc_id = 3'd1;
    exp_q.push_back(16'd0); tag_q.push_back("R11 read wins");
    @(negedge clk);
    acc_rd = 1'b0; acc_wr = 1'b0;
    #1 check("R11 blocked kept", 32'(blocked), 32'h04);
    rd(2'd0, 0, 16'd0, "R11 give dropped");

    // saturation
    @(negedge clk);
    acc_wr = 1'b1; acc_view = 2'd1; acc_id = 3'd0;
    repeat (65537) @(negedge clk);
    acc_wr = 1'b0;
    rd(2'd0, 0, 16'hFFFF, "R6 saturated");
    wr(2'd2, 0, 8'h00, 8'h00, "R6 give at max");
    rd(2'd2, 7, 16'hFFFF, "R6 take at max");
    rd(2'd0, 0, 16'hFFFE, "R6 after take");

    repeat (3) @(negedge clk);
    check("R2 scoreboard drained", 32'(exp_q.size()), 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule